// File: doc/BRIEF.md
# Byte/Word Arithmetic Logic Unit with Status Flags

This block is the integer execution core of a small processor datapath. It takes two 16-bit operands, a 4-bit operation code and a width select, and produces a result on the same cycle. The result goes out on a combinational path. Five status flags sit in a register that loads on the rising clock edge when the enable is high. The flags are carry, zero, negative, signed overflow and nibble carry.

Every operation runs either on the full word or on the low byte. In byte mode the flags are taken from bit 7 and bits 7:0. The upper half of the result is then operand A unchanged. Each operation class writes only its own subset of the flags. Subtraction is done by adding the inverted subtrahend. Carry and nibble carry therefore read as "no borrow" after a subtract. Add-with-carry and subtract-with-borrow can take their carry from the stored C flag or from the external carry input.

Top module: `bw_alu`

## Requirements
- R1: Additions: op 0 (ADD) gives A+B, op 1 (ADDC) gives A+B+stored C, op 2 (ADDX) gives A+B+carry_in. C is the carry out of the top bit of the selected width.
- R2: Subtractions are computed as A+~B+k. Op 3 (SUB) uses k=1, op 4 (SUBB) uses k=stored C and op 5 (SUBX) uses k=carry_in. C=1 means no borrow from the top bit of the selected width.
- R3: For ops 0 to 5, DC is the carry out of bit 3 in both widths. After a subtraction, DC=1 means no borrow from the low nibble.
- R4: For ops 0 to 5, OV is set when the two's-complement result overflows the selected width.
- R5: Ops 0 to 14 set Z exactly when the selected-width result is zero. The same ops load N with the top bit of the selected width.
- R6: The logical ops are op 6 (AND), op 7 (OR), op 8 (XOR) and op 9 (NOT A). They write only Z and N. C, OV and DC keep their values.
- R7: The shifts move by one bit. Op 10 is a left shift and op 11 a logical right shift. Op 12 is an arithmetic right shift. Op 13 rotates left through C and op 14 rotates right through C. C receives the bit shifted out. OV and DC keep their values.
- R8: With byte_mode=1, result[15:8] equals a[15:8] for every op.
- R9: With en=0, the status flags do not change.
- R10: Op 15 is reserved. Its result is A and it writes no flag.
- R11: Reset (rst_n low) clears all five flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Status register load enable |
| op | input | 4 | Operation code |
| byte_mode | input | 1 | 1 selects 8-bit operation |
| a | input | 16 | Operand A |
| b | input | 16 | Operand B |
| carry_in | input | 1 | External carry for ADDX and SUBX |
| result | output | 16 | Combinational result |
| flag_c | output | 1 | Carry / not-borrow |
| flag_z | output | 1 | Zero |
| flag_n | output | 1 | Negative |
| flag_ov | output | 1 | Signed overflow |
| flag_dc | output | 1 | Nibble carry / not-borrow |

## Verification
The assertions assume that op, byte_mode, a, b and en are stable around each rising edge. Under that assumption the result sampled at one edge is the value that was used to load the flags. Zero and negative are therefore checked against the previous cycle's result port, and a flag whose write is masked off must hold its value. The bench changes inputs only on the falling edge. It draws every opcode, including the reserved one, with both widths and a mostly-high enable. Directed cases drive the carry, overflow and nibble-borrow boundaries in both widths.

// File: rtl/bw_alu_pkg.sv
package bw_alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADDC = 4'd1,
    OP_ADDX = 4'd2,
    OP_SUB  = 4'd3,
    OP_SUBB = 4'd4,
    OP_SUBX = 4'd5,
    OP_AND  = 4'd6,
    OP_OR   = 4'd7,
    OP_XOR  = 4'd8,
    OP_NOT  = 4'd9,
    OP_SHL  = 4'd10,
    OP_SHR  = 4'd11,
    OP_ASR  = 4'd12,
    OP_RLC  = 4'd13,
    OP_RRC  = 4'd14,
    OP_RSVD = 4'd15
  } alu_op_e;

  typedef enum logic [2:0] {
    SH_LEFT,
    SH_RIGHT,
    SH_ARITH,
    SH_ROTL,
    SH_ROTR
  } shift_e;

  typedef struct packed {
    logic c;
    logic z;
    logic n;
    logic ov;
    logic dc;
  } flags_t;

  function automatic logic op_is_arith(alu_op_e o);
    return (o <= OP_SUBX);
  endfunction

  function automatic logic op_is_sub(alu_op_e o);
    return (o == OP_SUB) || (o == OP_SUBB) || (o == OP_SUBX);
  endfunction

  function automatic logic op_is_logic(alu_op_e o);
    return (o >= OP_AND) && (o <= OP_NOT);
  endfunction

  function automatic logic op_is_shift(alu_op_e o);
    return (o >= OP_SHL) && (o <= OP_RRC);
  endfunction

  // which status bits each operation class is allowed to write
  function automatic flags_t flag_write_mask(alu_op_e o);
    flags_t m;
    m = '0;
    if (op_is_arith(o)) begin
      m = '1;
    end else if (op_is_logic(o)) begin
      m.z = 1'b1;
      m.n = 1'b1;
    end else if (op_is_shift(o)) begin
      m.c = 1'b1;
      m.z = 1'b1;
      m.n = 1'b1;
    end
    return m;
  endfunction

  function automatic shift_e shift_kind(alu_op_e o);
    case (o)
      OP_SHL:  return SH_LEFT;
      OP_SHR:  return SH_RIGHT;
      OP_ASR:  return SH_ARITH;
      OP_RLC:  return SH_ROTL;
      default: return SH_ROTR;
    endcase
  endfunction

endpackage

// File: rtl/bw_alu_adder.sv
module bw_alu_adder #(
  parameter int W = 16
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         ci,
  output logic [W-1:0] s,
  output logic [W:0]   cv
);

  // ripple chain that exposes the carry into every bit position
  function automatic logic [W:0] carry_chain(logic [W-1:0] p, logic [W-1:0] q, logic c0);
    logic [W:0] c;
    c[0] = c0;
    for (int i = 0; i < W; i++) begin
      c[i+1] = (p[i] & q[i]) | (c[i] & (p[i] ^ q[i]));
    end
    return c;
  endfunction

  always_comb begin
    cv = carry_chain(x, y, ci);
    s  = x ^ y ^ cv[W-1:0];
  end

endmodule

// File: rtl/bw_alu_shift.sv
module bw_alu_shift
  import bw_alu_pkg::*;
#(
  parameter int DW = 16,
  parameter int BW = DW / 2
) (
  input  logic [DW-1:0] x,
  input  logic          bm,
  input  shift_e        kind,
  input  logic          ci,
  output logic [DW-1:0] y,
  output logic          co
);

  logic [DW-1:0] lin;
  logic [DW-1:0] rin;
  logic          x_top;
  logic          lsb_fill;
  logic          msb_fill;
  logic          go_left;

  assign x_top   = bm ? x[BW-1] : x[DW-1];
  assign go_left = (kind == SH_LEFT) || (kind == SH_ROTL);
  assign lsb_fill = (kind == SH_ROTL) ? ci : 1'b0;

  always_comb begin
    case (kind)
      SH_ARITH: msb_fill = x_top;
      SH_ROTR:  msb_fill = ci;
      default:  msb_fill = 1'b0;
    endcase
  end

  for (genvar i = 0; i < DW; i++) begin : g_bit
    if (i == 0) begin : g_lo
      assign lin[i] = lsb_fill;
    end else begin : g_mid
      assign lin[i] = x[i-1];
    end
    if (i == DW-1) begin : g_wtop
      assign rin[i] = msb_fill;
    end else if (i == BW-1) begin : g_btop
      assign rin[i] = bm ? msb_fill : x[i+1];
    end else begin : g_rest
      assign rin[i] = x[i+1];
    end
  end

  assign y  = go_left ? lin : rin;
  assign co = go_left ? x_top : x[0];

endmodule

// File: rtl/bw_alu_status.sv
module bw_alu_status
  import bw_alu_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   en,
  input  flags_t wr,
  input  flags_t nxt,
  output flags_t cur
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur <= '0;
    end else if (en) begin
      cur <= (cur & ~wr) | (nxt & wr);
    end
  end

endmodule

// File: rtl/bw_alu.sv
module bw_alu
  import bw_alu_pkg::*;
#(
  parameter int DW  = 16,
  parameter int NIB = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [3:0]    op,
  input  logic          byte_mode,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          carry_in,
  output logic [DW-1:0] result,
  output logic          flag_c,
  output logic          flag_z,
  output logic          flag_n,
  output logic          flag_ov,
  output logic          flag_dc
);

  localparam int BW = DW / 2;

  alu_op_e       op_e;
  flags_t        st;
  flags_t        nxt;
  flags_t        upd_mask;
  logic          add_ci;
  logic [DW-1:0] b_eff;
  logic [DW-1:0] sum;
  logic [DW:0]   cv;
  logic [DW-1:0] sh_y;
  logic          sh_co;
  logic [DW-1:0] core_r;
  logic          sel_msb;
  logic          sel_zero;

  assign op_e = alu_op_e'(op);

  // carry entering the adder for each arithmetic flavour
  always_comb begin
    case (op_e)
      OP_ADDC, OP_SUBB: add_ci = st.c;
      OP_ADDX, OP_SUBX: add_ci = carry_in;
      OP_SUB:           add_ci = 1'b1;
      default:          add_ci = 1'b0;
    endcase
  end

  assign b_eff = op_is_sub(op_e) ? ~b : b;

  bw_alu_adder #(.W(DW)) u_add (
    .x  (a),
    .y  (b_eff),
    .ci (add_ci),
    .s  (sum),
    .cv (cv)
  );

  bw_alu_shift #(.DW(DW), .BW(BW)) u_shift (
    .x    (a),
    .bm   (byte_mode),
    .kind (shift_kind(op_e)),
    .ci   (st.c),
    .y    (sh_y),
    .co   (sh_co)
  );

  always_comb begin
    case (op_e)
      OP_AND:  core_r = a & b;
      OP_OR:   core_r = a | b;
      OP_XOR:  core_r = a ^ b;
      OP_NOT:  core_r = ~a;
      OP_RSVD: core_r = a;
      default: core_r = op_is_shift(op_e) ? sh_y : sum;
    endcase
  end

  assign result   = byte_mode ? {a[DW-1:BW], core_r[BW-1:0]} : core_r;
  assign sel_msb  = byte_mode ? core_r[BW-1] : core_r[DW-1];
  assign sel_zero = byte_mode ? (core_r[BW-1:0] == '0) : (core_r == '0);

  always_comb begin
    nxt.z  = sel_zero;
    nxt.n  = sel_msb;
    nxt.dc = cv[NIB];
    nxt.ov = byte_mode ? (cv[BW] ^ cv[BW-1]) : (cv[DW] ^ cv[DW-1]);
    if (op_is_shift(op_e)) begin
      nxt.c = sh_co;
    end else begin
      nxt.c = byte_mode ? cv[BW] : cv[DW];
    end
  end

  assign upd_mask = flag_write_mask(op_e);

  bw_alu_status u_status (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en),
    .wr    (upd_mask),
    .nxt   (nxt),
    .cur   (st)
  );

  assign flag_c  = st.c;
  assign flag_z  = st.z;
  assign flag_n  = st.n;
  assign flag_ov = st.ov;
  assign flag_dc = st.dc;

endmodule

// File: rtl/bw_alu_chk.sv
module bw_alu_chk #(
  parameter int DW = 16,
  parameter int BW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic [3:0]    op,
  input logic          byte_mode,
  input logic [DW-1:0] a,
  input logic [DW-1:0] result,
  input logic [4:0]    upd_mask,
  input logic          flag_c,
  input logic          flag_z,
  input logic          flag_n,
  input logic          flag_ov,
  input logic          flag_dc
);

  logic [4:0] fl;
  assign fl = {flag_c, flag_z, flag_n, flag_ov, flag_dc};

  a_r8_upper_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    byte_mode |-> (result[DW-1:BW] == a[DW-1:BW]));

  a_r9_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(fl));

  a_r10_reserved_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op == 4'd15) |=> $stable(fl));

  a_r10_reserved_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 4'd15) |-> (result == a));

  a_r6_logic_keeps_c_ov_dc: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op >= 4'd6 && op <= 4'd9) |=> $stable({flag_c, flag_ov, flag_dc}));

  a_r7_shift_keeps_ov_dc: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op >= 4'd10 && op <= 4'd14) |=> $stable({flag_ov, flag_dc}));

  a_r5_zero_tracks_result: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op != 4'd15) |=>
      (flag_z == ($past(byte_mode) ? ($past(result[BW-1:0]) == '0) : ($past(result) == '0))));

  a_r5_neg_tracks_result: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op != 4'd15) |=>
      (flag_n == ($past(byte_mode) ? $past(result[BW-1]) : $past(result[DW-1]))));

  a_r9_masked_carry_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_mask[4] |=> $stable(flag_c));

endmodule

bind bw_alu bw_alu_chk #(.DW(DW), .BW(BW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .en        (en),
  .op        (op),
  .byte_mode (byte_mode),
  .a         (a),
  .result    (result),
  .upd_mask  (upd_mask),
  .flag_c    (flag_c),
  .flag_z    (flag_z),
  .flag_n    (flag_n),
  .flag_ov   (flag_ov),
  .flag_dc   (flag_dc)
);

// File: tb/bw_alu_bench.sv
`timescale 1ns/1ps
module bw_alu_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [3:0]  op = '0;
  logic        byte_mode = 1'b0;
  logic [15:0] a = '0;
  logic [15:0] b = '0;
  logic        carry_in = 1'b0;
  logic [15:0] result;
  logic        flag_c, flag_z, flag_n, flag_ov, flag_dc;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  bit [4:0] st_m = '0;

  always #4 clk = ~clk;

  bw_alu u_bw_alu (
    .clk(clk), .rst_n(rst_n), .en(en), .op(op), .byte_mode(byte_mode),
    .a(a), .b(b), .carry_in(carry_in), .result(result),
    .flag_c(flag_c), .flag_z(flag_z), .flag_n(flag_n),
    .flag_ov(flag_ov), .flag_dc(flag_dc)
  );

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of(int o);
    if (o <= 2) return "R1";
    if (o <= 5) return "R2";
    if (o <= 9) return "R6";
    if (o <= 14) return "R7";
    return "R10";
  endfunction

  // expected behaviour, written with integer arithmetic; flags as {c,z,n,ov,dc}
  function automatic void model(input int o, input bit bm, input int a16, input int b16,
                                input bit cx, input bit cs,
                                output int res, output bit [4:0] f, output bit [4:0] m);
    int w, mk, half, av, bv, r, ci, bb, s, sa, sb, sv;
    bit c, ov, dc, z, n;
    w = bm ? 8 : 16;
    mk = (1 << w) - 1;
    half = 1 << (w - 1);
    av = a16 & mk;
    bv = b16 & mk;
    r = 0; c = 0; ov = 0; dc = 0;
    if (o <= 5) begin
      if (o == 0) ci = 0;
      else if (o == 3) ci = 1;
      else if (o == 1 || o == 4) ci = cs;
      else ci = cx;
      bb = (o >= 3) ? ((~bv) & mk) : bv;
      s = av + bb + ci;
      r = s & mk;
      c = (s >> w) & 1;
      dc = (((av & 15) + (bb & 15) + ci) >> 4) & 1;
      sa = (av >= half) ? av - (1 << w) : av;
      sb = (bv >= half) ? bv - (1 << w) : bv;
      sv = (o >= 3) ? sa - sb - (1 - ci) : sa + sb + ci;
      ov = (sv < -half) || (sv > half - 1);
      m = 5'b11111;
    end else if (o <= 9) begin
      case (o)
        6: r = av & bv;
        7: r = av | bv;
        8: r = av ^ bv;
        default: r = (~av) & mk;
      endcase
      m = 5'b01100;
    end else if (o <= 14) begin
      case (o)
        10: begin r = (av << 1) & mk; c = (av >> (w - 1)) & 1; end
        11: begin r = av >> 1; c = av & 1; end
        12: begin r = (av >> 1) | (av & half); c = av & 1; end
        13: begin r = ((av << 1) | cs) & mk; c = (av >> (w - 1)) & 1; end
        default: begin r = (av >> 1) | (cs ? half : 0); c = av & 1; end
      endcase
      m = 5'b11100;
    end else begin
      r = av;
      m = 5'b00000;
    end
    z = (r == 0);
    n = (r >> (w - 1)) & 1;
    f = {c, z, n, ov, dc};
    res = bm ? ((a16 & 'hFF00) | r) : r;
  endfunction

  task automatic run_op(int o, bit bm, int av, int bv, bit cx, bit e);
    int exp_r;
    bit [4:0] f, m;
    string t;
    @(negedge clk);
    op = o[3:0]; byte_mode = bm; a = av[15:0]; b = bv[15:0]; carry_in = cx; en = e;
    #1;
    model(o, bm, av, bv, cx, st_m[4], exp_r, f, m);
    t = tag_of(o);
    chk(t, "result", int'(result), exp_r);
    if (bm) chk("R8", "upper byte", int'(result[15:8]), (av >> 8) & 'hFF);
    @(posedge clk);
    if (e) st_m = (st_m & ~m) | (f & m);
    #2;
    if (!e) t = "R9";
    chk(t, "C", int'(flag_c), int'(st_m[4]));
    chk((o <= 14 && e) ? "R5" : t, "Z", int'(flag_z), int'(st_m[3]));
    chk((o <= 14 && e) ? "R5" : t, "N", int'(flag_n), int'(st_m[2]));
    chk((o <= 5 && e) ? "R4" : t, "OV", int'(flag_ov), int'(st_m[1]));
    chk((o <= 5 && e) ? "R3" : t, "DC", int'(flag_dc), int'(st_m[0]));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    // R11: reset clears the flags
    repeat (3) @(posedge clk);
    #2;
    chk("R11", "flags in reset", int'({flag_c, flag_z, flag_n, flag_ov, flag_dc}), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #2;
    chk("R11", "flags after reset", int'({flag_c, flag_z, flag_n, flag_ov, flag_dc}), 0);

    // directed corners
    run_op(0, 0, 'h7FFF, 'h0001, 0, 1);  // R4 word overflow
    run_op(0, 0, 'hFFFF, 'h0001, 0, 1);  // R1 carry out, zero
    run_op(0, 1, 'hAB7F, 'h1201, 0, 1);  // R8 byte overflow, upper kept
    run_op(0, 0, 'h000F, 'h0001, 0, 1);  // R3 nibble carry
    run_op(3, 0, 'h0000, 'h0001, 0, 1);  // R2 borrow, C=0
    run_op(3, 0, 'h1234, 'h1234, 0, 1);  // R2 equal, C=1 Z=1
    run_op(3, 0, 'h0010, 'h0001, 0, 1);  // R3 nibble borrow, DC=0
    run_op(3, 1, 'hCD80, 'h0001, 0, 1);  // R4 byte sub overflow
    run_op(0, 0, 'hFFFF, 'h0001, 0, 1);  // set C
    run_op(6, 0, 'h00F0, 'h0F0F, 0, 1);  // R6 logic keeps C
    run_op(1, 0, 'h0001, 'h0001, 0, 1);  // R1 ADDC with stored C=1
    run_op(5, 1, 'h0005, 'h0005, 1, 1);  // R2 SUBX external no-borrow
    run_op(10, 1, 'h5580, 'h0000, 0, 1); // R7 byte shift-out to C
    run_op(13, 0, 'h4000, 'h0000, 0, 1); // R7 rotate through C
    run_op(12, 0, 'h8002, 'h0000, 0, 1); // R7 arithmetic right
    run_op(14, 1, 'h0101, 'h0000, 0, 1); // R7 rotate right byte
    run_op(15, 0, 'hBEEF, 'h0000, 1, 1); // R10 reserved
    run_op(0, 0, 'hFFFF, 'hFFFF, 0, 0);  // R9 disabled

    for (int i = 0; i < 3000; i++) begin
      int o, av, bv;
      bit bm, cx, e;
      o = int'($urandom % 16);
      bm = $urandom % 2;
      cx = $urandom % 2;
      e = ($urandom % 8) != 0;
      av = int'($urandom & 'hFFFF);
      bv = int'($urandom & 'hFFFF);
      if (($urandom % 6) == 0) bv = av;
      run_op(o, bm, av, bv, cx, e);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule